// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures the frequency of a conditioned intermediate-frequency pulse train. It counts rising edges of the input inside a gate window of known length. The count is then held in a 20-bit binary register until the host clears it. The host writes a control word and marks it with a strobe. The word takes effect on the strobe's falling edge. It carries a count-enable bit and a two-bit gate-length select.

Writing the enable bit as 0 clears the count and returns the block to idle. Changing the enable bit from 0 to 1 arms a measurement. After arming, the block waits two timebase ticks so that the IF signal has time to settle. It then opens the gate for 1, 4, 8 or 32 ticks. When the gate closes, the block raises a done flag. The frozen count is presented in parallel to a serial shift-out stage, which sends it most significant bit first.

The IF input is treated as asynchronous. It passes through a synchronizer and an edge detector in the system clock domain. The tick is derived from the system clock by a prescaler of `TICK_DIV` cycles; the default gives 1 kHz from 200 MHz.

Top module: `ifc_gated_counter`

## Requirements
- R1: After reset, the count is 0 and both busy and done are low.
- R2: The control word takes effect only on a falling edge of the strobe. Changes to the enable bit or gate select while the strobe is steady have no effect. A rising edge of the strobe also has no effect.
- R3: A write with the enable bit at 0 sets the count to 0 and drops busy and done. This holds even in the middle of a measurement.
- R4: A write that changes the enable bit from 0 to 1 raises busy. Busy is visible in the cycle after the strobe-fall edge. A wait of 2 ticks follows, and IF edges during that wait are not counted.
- R5: The gate select picks the gate length: 0 gives 1 tick, 1 gives 4, 2 gives 8 and 3 gives 32. Done rises exactly (2 + gate ticks) × `TICK_DIV` clocks after the strobe-fall edge.
- R6: Each rising edge of the IF input inside the gate adds one to the count. This assumes each high and low phase lasts at least 2 clocks. Outside the gate, the count does not move.
- R7: While done is high, the count stays frozen and IF edges are ignored.
- R8: A write with the enable bit at 1 while the latched enable is already 1 has no effect. It does not re-arm the block, and the new gate select is ignored.
- R9: The count saturates at all ones instead of wrapping to 0.
- R10: Busy and done are never high together. Busy falls in the same cycle that done rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ctl_strobe | input | 1 | Control strobe; the control word is taken on its falling edge |
| ctl_cnt_en | input | 1 | Count-enable bit: 0 clears, a change from 0 to 1 arms |
| ctl_gate_sel | input | 2 | Gate-length select |
| if_pulse | input | 1 | Conditioned IF pulse input (asynchronous) |
| meas_count | output | CNT_W | Count value, presented to the MSB-first shift-out |
| meas_busy | output | 1 | High during the wait and the gate |
| meas_done | output | 1 | High once the gate has closed, until the next clear |

## Verification
Some properties are checked on every cycle. Busy and done are never high together. The count stays at zero during the wait. It never moves outside the gate and never steps by more than one. It does not wrap from all ones, it is zero after every clear, and it stays frozen while done holds.

The bench's scenarios are needed for the rest. They show the exact cycle on which done rises for each gate select. They show the exact count for a known pulse train. They show that strobe rises, and writes that only repeat the enable, are ignored. The saturation value is observed on a narrow-count instance.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_GATE = 2'd2,
    ST_DONE = 2'd3
  } ifc_state_e;

  localparam int unsigned SEL_W = 2;
endpackage

// File: rtl/ifc_rst_sync.sv
module ifc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_nxt;

  always_comb begin
    stage_nxt = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_nxt;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/ifc_ctl.sv
module ifc_ctl
  import ifc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic             cfg_en,
  input  logic [SEL_W-1:0] cfg_gate,
  output logic             arm,
  output logic             clr,
  output logic [SEL_W-1:0] gate_q
);
  logic             strobe_d;
  logic             en_q;
  logic             en_nxt;
  logic [SEL_W-1:0] gate_nxt;
  logic             strobe_fall;

  // Control decode: edge of strobe, arm on 0->1, clear on 0
  always_comb begin
    strobe_fall = strobe_d & ~strobe;
    arm         = strobe_fall & cfg_en & ~en_q;
    clr         = strobe_fall & ~cfg_en;
    en_nxt      = strobe_fall ? cfg_en : en_q;
    gate_nxt    = arm ? cfg_gate : gate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d <= 1'b0;
      en_q     <= 1'b0;
      gate_q   <= '0;
    end else begin
      strobe_d <= strobe;
      en_q     <= en_nxt;
      gate_q   <= gate_nxt;
    end
  end
endmodule

// File: rtl/ifc_seq.sv
module ifc_seq
  import ifc_pkg::*;
#(
  parameter int unsigned TICK_DIV   = 200000,
  parameter int unsigned WAIT_TICKS = 2,
  parameter int unsigned GATE_T0    = 1,
  parameter int unsigned GATE_T1    = 4,
  parameter int unsigned GATE_T2    = 8,
  parameter int unsigned GATE_T3    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             clr,
  input  logic [SEL_W-1:0] gate_q,
  output logic             busy,
  output logic             done,
  output logic             gate_open
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned MAX_A = (GATE_T0 > GATE_T1) ? GATE_T0 : GATE_T1;
  localparam int unsigned MAX_B = (GATE_T2 > GATE_T3) ? GATE_T2 : GATE_T3;
  localparam int unsigned MAX_G = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned MAX_T = (MAX_G > WAIT_TICKS) ? MAX_G : WAIT_TICKS;
  localparam int unsigned TK_W  = $clog2(MAX_T + 1);
  localparam logic [PRE_W-1:0] PRE_LAST  = PRE_W'(TICK_DIV - 1);
  localparam logic [TK_W-1:0]  WAIT_LAST = TK_W'(WAIT_TICKS - 1);

  ifc_state_e       state_q, state_nxt;
  logic [PRE_W-1:0] pre_q, pre_nxt;
  logic [TK_W-1:0]  tk_q, tk_nxt;
  logic [TK_W-1:0]  gate_last;
  logic             run;
  logic             tick;

  always_comb begin
    case (gate_q)
      2'd0:    gate_last = TK_W'(GATE_T0 - 1);
      2'd1:    gate_last = TK_W'(GATE_T1 - 1);
      2'd2:    gate_last = TK_W'(GATE_T2 - 1);
      default: gate_last = TK_W'(GATE_T3 - 1);
    endcase
  end

  always_comb begin
    run       = (state_q == ST_WAIT) || (state_q == ST_GATE);
    tick      = run && (pre_q == PRE_LAST);
    state_nxt = state_q;
    pre_nxt   = pre_q;
    tk_nxt    = tk_q;
    if (clr) begin
      state_nxt = ST_IDLE;
      pre_nxt   = '0;
      tk_nxt    = '0;
    end else if (arm) begin
      state_nxt = ST_WAIT;
      pre_nxt   = '0;
      tk_nxt    = '0;
    end else if (run) begin
      pre_nxt = tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        if (state_q == ST_WAIT && tk_q == WAIT_LAST) begin
          state_nxt = ST_GATE;
          tk_nxt    = '0;
        end else if (state_q == ST_GATE && tk_q == gate_last) begin
          state_nxt = ST_DONE;
          tk_nxt    = '0;
        end else begin
          tk_nxt = tk_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pre_q   <= '0;
      tk_q    <= '0;
    end else begin
      state_q <= state_nxt;
      pre_q   <= pre_nxt;
      tk_q    <= tk_nxt;
    end
  end

  assign busy      = run;
  assign done      = (state_q == ST_DONE);
  assign gate_open = (state_q == ST_GATE);
endmodule

// File: rtl/ifc_edge_cnt.sv
module ifc_edge_cnt #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             if_in,
  input  logic             clr,
  input  logic             arm,
  input  logic             gate_open,
  output logic [CNT_W-1:0] count
);
  logic [SYNC_N:0]    sh_q, sh_nxt;
  logic [CNT_W-1:0]   cnt_q, cnt_nxt;
  logic               rise;
  logic               sat;

  always_comb begin
    sh_nxt  = {sh_q[SYNC_N-1:0], if_in};
    rise    = sh_q[SYNC_N-1] & ~sh_q[SYNC_N];
    sat     = &cnt_q;
    cnt_nxt = cnt_q;
    if (clr || arm)                  cnt_nxt = '0;
    else if (gate_open && rise && !sat) cnt_nxt = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_nxt;
      cnt_q <= cnt_nxt;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/ifc_gated_counter.sv
module ifc_gated_counter
  import ifc_pkg::*;
#(
  parameter int unsigned CNT_W      = 20,
  parameter int unsigned TICK_DIV   = 200000,
  parameter int unsigned WAIT_TICKS = 2,
  parameter int unsigned GATE_T0    = 1,
  parameter int unsigned GATE_T1    = 4,
  parameter int unsigned GATE_T2    = 8,
  parameter int unsigned GATE_T3    = 32,
  parameter int unsigned SYNC_N     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_strobe,
  input  logic             ctl_cnt_en,
  input  logic [1:0]       ctl_gate_sel,
  input  logic             if_pulse,
  output logic [CNT_W-1:0] meas_count,
  output logic             meas_busy,
  output logic             meas_done
);
  logic             rst_int_n;
  logic             arm_req;
  logic             clr_req;
  logic [SEL_W-1:0] gate_sel_q;
  logic             gate_open;

  ifc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ifc_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .strobe   (ctl_strobe),
    .cfg_en   (ctl_cnt_en),
    .cfg_gate (ctl_gate_sel),
    .arm      (arm_req),
    .clr      (clr_req),
    .gate_q   (gate_sel_q)
  );

  ifc_seq #(
    .TICK_DIV   (TICK_DIV),
    .WAIT_TICKS (WAIT_TICKS),
    .GATE_T0    (GATE_T0),
    .GATE_T1    (GATE_T1),
    .GATE_T2    (GATE_T2),
    .GATE_T3    (GATE_T3)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .arm       (arm_req),
    .clr       (clr_req),
    .gate_q    (gate_sel_q),
    .busy      (meas_busy),
    .done      (meas_done),
    .gate_open (gate_open)
  );

  ifc_edge_cnt #(
    .CNT_W  (CNT_W),
    .SYNC_N (SYNC_N)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .if_in     (if_pulse),
    .clr       (clr_req),
    .arm       (arm_req),
    .gate_open (gate_open),
    .count     (meas_count)
  );
endmodule

// File: rtl/ifc_gated_counter_chk.sv
module ifc_gated_counter_chk #(
  parameter int unsigned CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] count,
  input logic             clr,
  input logic             arm,
  input logic             gate_open
);
  localparam logic [CNT_W-1:0] ONES = '1;

  a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r3_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0 && !busy && !done));

  a_r4_wait_holds_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !gate_open) |-> (count == '0));

  a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !arm) |=> (count == $past(count) || count == $past(count) + 1'b1));

  a_r6_gate_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !clr && !arm) |=> $stable(count));

  a_r7_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !clr) |=> (done && $stable(count)));

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (count == ONES && !clr && !arm) |=> (count == ONES));
endmodule

bind ifc_gated_counter ifc_gated_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (meas_busy),
  .done      (meas_done),
  .count     (meas_count),
  .clr       (clr_req),
  .arm       (arm_req),
  .gate_open (gate_open)
);

// File: tb/tb_ifc_gated_counter.sv
`timescale 1ns/1ps
module tb_ifc_gated_counter;
  localparam int TD    = 40;
  localparam int SAT_W = 4;

  logic        clk;
  logic        rst_n;
  logic        strobe;
  logic        cnt_en;
  logic [1:0]  gate_sel;
  logic        if_pulse;
  logic [19:0] count;
  logic        busy;
  logic        done;
  logic [SAT_W-1:0] sat_count;
  logic        sat_busy;
  logic        sat_done;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int arm_edge = 0;
  bit finished = 0;

  ifc_gated_counter #(.CNT_W(20), .TICK_DIV(TD)) dut (
    .clk(clk), .rst_n(rst_n), .ctl_strobe(strobe), .ctl_cnt_en(cnt_en),
    .ctl_gate_sel(gate_sel), .if_pulse(if_pulse),
    .meas_count(count), .meas_busy(busy), .meas_done(done)
  );

  ifc_gated_counter #(.CNT_W(SAT_W), .TICK_DIV(TD)) dut_sat (
    .clk(clk), .rst_n(rst_n), .ctl_strobe(strobe), .ctl_cnt_en(cnt_en),
    .ctl_gate_sel(gate_sel), .if_pulse(if_pulse),
    .meas_count(sat_count), .meas_busy(sat_busy), .meas_done(sat_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_until(input int edge_no);
    while (cyc < edge_no) @(negedge clk);
  endtask

  task automatic strobe_write(input logic en, input logic [1:0] sel);
    @(negedge clk);
    cnt_en   = en;
    gate_sel = sel;
    strobe   = 1'b1;
    @(negedge clk);
    strobe   = 1'b0;
    arm_edge = cyc + 1;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if_pulse = 1'b1;
      @(negedge clk);
      @(negedge clk); if_pulse = 1'b0;
      @(negedge clk);
    end
  endtask

  function automatic int gate_ticks(input int sel);
    case (sel)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 32;
    endcase
  endfunction

  task automatic t_reset;
    chk("R1", "count after reset", int'(count), 0);
    chk("R1", "busy after reset", int'(busy), 0);
    chk("R1", "done after reset", int'(done), 0);
  endtask

  task automatic t_measure(input int sel, input int n);
    int d;
    int sat_exp;
    d = (2 + gate_ticks(sel)) * TD;
    sat_exp = (n > 15) ? 15 : n;
    strobe_write(1'b0, 2'(sel));
    repeat (3) @(negedge clk);
    chk("R3", "count after clear", int'(count), 0);
    chk("R3", "busy after clear", int'(busy), 0);
    strobe_write(1'b1, 2'(sel));
    wait_until(arm_edge);
    chk("R4", "busy after arm", int'(busy), 1);
    pulses(5);
    chk("R4", "count after edges in wait", int'(count), 0);
    wait_until(arm_edge + 2 * TD + 2);
    pulses(n);
    wait_until(arm_edge + d - 1);
    chk("R5", "done one cycle early", int'(done), 0);
    chk("R5", "busy one cycle early", int'(busy), 1);
    wait_until(arm_edge + d);
    chk("R5", "done at gate end", int'(done), 1);
    chk("R10", "busy at gate end", int'(busy), 0);
    chk("R6", "count of gate edges", int'(count), n);
    chk("R9", "saturated narrow count", int'(sat_count), sat_exp);
    pulses(3);
    chk("R7", "count frozen after done", int'(count), n);
    chk("R7", "done held", int'(done), 1);
    strobe_write(1'b1, 2'(sel ^ 1));
    repeat (5) @(negedge clk);
    chk("R8", "done after repeated enable", int'(done), 1);
    chk("R8", "busy after repeated enable", int'(busy), 0);
    chk("R8", "count after repeated enable", int'(count), n);
  endtask

  task automatic t_abort;
    strobe_write(1'b0, 2'd1);
    strobe_write(1'b1, 2'd1);
    wait_until(arm_edge + 2 * TD + 2);
    pulses(4);
    chk("R6", "count mid gate", int'(count), 4);
    chk("R6", "busy mid gate", int'(busy), 1);
    strobe_write(1'b0, 2'd1);
    wait_until(arm_edge);
    chk("R3", "count after abort", int'(count), 0);
    chk("R3", "busy after abort", int'(busy), 0);
    chk("R3", "done after abort", int'(done), 0);
  endtask

  task automatic t_ignore;
    @(negedge clk);
    cnt_en   = 1'b1;
    gate_sel = 2'd3;
    repeat (50) @(negedge clk);
    chk("R2", "busy with steady strobe", int'(busy), 0);
    strobe = 1'b1;
    repeat (10) @(negedge clk);
    chk("R2", "busy after strobe rise", int'(busy), 0);
    strobe = 1'b0;
    arm_edge = cyc + 1;
    wait_until(arm_edge);
    chk("R2", "busy after strobe fall", int'(busy), 1);
    strobe_write(1'b0, 2'd0);
    wait_until(arm_edge);
    chk("R3", "busy after final clear", int'(busy), 0);
  endtask

  initial begin
    rst_n    = 1'b0;
    strobe   = 1'b0;
    cnt_en   = 1'b0;
    gate_sel = 2'd0;
    if_pulse = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_measure(0, 3);
    t_measure(1, 10);
    t_measure(2, 20);
    t_measure(3, 50);
    t_abort();
    t_ignore();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule